// File: doc/BRIEF.md
# Interrupt Status and Mask Controller

This block gathers interrupt requests from peripherals into a sticky status register and qualifies them with a mask register. It drives one interrupt line to the CPU. Each source raises its status bit with a one-cycle request pulse, and the bit then stays set until software clears it. The DMA engine has its own request input, which lands on a fixed status bit. The CPU line is high whenever a status bit is set and its mask bit is also set.

Software reaches both registers through a small register bus. The bus has an address, a write strobe, a read strobe and a width select that picks a 16-bit or 32-bit access. A write to the status register does not store the value. It ANDs the value into the register, so software acknowledges a source by writing 0 to that source's bit and 1 to every other bit. A write to the mask register replaces its contents. Because the CPU line is recomputed from the registers every cycle, unmasking a source that is already pending raises the line without any new request.

The reset input is asynchronous and active low. It is released synchronously inside the block, two clock cycles after `rst_n` rises.

Top module: `irqc_top`

## Requirements
- R1: After reset, the status register, the mask register and `cpu_irq` are all zero, and reads of both registers return 0.
- R2: A pulse on `src_req[i]` sets status bit i at the next clock edge. The bit stays set after the pulse ends.
- R3: A 32-bit write (`bus_wide`=1) to offset 0x0 sets status to status AND `bus_wdata`. A bus write never sets a status bit.
- R4: A 16-bit write (`bus_wide`=0) to offset 0x0 ANDs only `bus_wdata[15:0]` into status bits 15..0. Bits 31..16 keep their values.
- R5: A 32-bit write to offset 0x4 loads the whole mask register with `bus_wdata`.
- R6: A 16-bit write to offset 0x4 loads mask bits 15..0 from `bus_wdata[15:0]`. Mask bits 31..16 keep their values.
- R7: `cpu_irq` is registered. It is 1 in the cycle after (status AND mask) is nonzero, and 0 in the cycle after (status AND mask) is zero.
- R8: A mask write that enables a status bit which is already set raises `cpu_irq` one cycle later, with no new request.
- R9: If a request and a clearing status write reach the same bit in the same cycle, the bit ends up set.
- R10: A pulse on `dma_req` sets status bit 3.
- R11: With `bus_rd`=1, offset 0x0 reads status and offset 0x4 reads mask. A 16-bit read returns the low half zero-extended. Any other offset reads 0. Writes to any other offset change neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| src_req | input | NUM_SRC | Per-source request pulses; bit i sets status bit i |
| dma_req | input | 1 | DMA request pulse; sets status bit DMA_BIT (3) |
| bus_addr | input | ADDR_W | Register byte offset: 0x0 is status, 0x4 is mask |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wide | input | 1 | 1 selects a 32-bit access, 0 selects a 16-bit access to the low half |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational); 0 when no read is active |
| cpu_irq | output | 1 | Registered interrupt request to the CPU |

## Verification
The assertions check these rules on every cycle:
- a request is never lost, including when a write clears the same bit;
- a write never creates a status bit;
- the mask loads exactly what was written;
- a 16-bit mask write leaves the upper half alone;
- `cpu_irq` follows (status AND mask) with one cycle of lag;
- a write to a stray offset leaves the mask unchanged.

Only the bench scenarios can show the rest:
- the full sequence of acknowledging through AND-writes with a mix of access widths;
- the zero-extended 16-bit read;
- a late unmask that raises the line for a source that was pending long before;
- zero reads from offsets with no register behind them.

// File: rtl/irqc_pkg.sv
`timescale 1ns/1ps
package irqc_pkg;
  localparam int BUS_W      = 32;
  localparam int HALF_W     = 16;
  localparam int STATUS_OFF = 0;
  localparam int MASK_OFF   = 4;

  typedef enum logic [1:0] {
    SEL_NONE   = 2'd0,
    SEL_STATUS = 2'd1,
    SEL_MASK   = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/irqc_rst_sync.sv
`timescale 1ns/1ps
module irqc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_sync_n = stage2_q;
endmodule

// File: rtl/irqc_bus_decode.sv
`timescale 1ns/1ps
module irqc_bus_decode
  import irqc_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int ADDR_W  = 4
) (
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic               bus_wide,
  output logic               stat_wr,
  output logic               mask_wr,
  output reg_sel_e           rd_sel,
  output logic [NUM_SRC-1:0] lane
);
  logic hit_status;
  logic hit_mask;

  assign hit_status = (bus_addr == ADDR_W'(STATUS_OFF));
  assign hit_mask   = (bus_addr == ADDR_W'(MASK_OFF));
  assign stat_wr    = bus_wr & hit_status;
  assign mask_wr    = bus_wr & hit_mask;

  always_comb begin
    rd_sel = SEL_NONE;
    if (bus_rd) begin
      if (hit_status)    rd_sel = SEL_STATUS;
      else if (hit_mask) rd_sel = SEL_MASK;
    end
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_lane
    if (i < HALF_W) begin : g_low
      assign lane[i] = 1'b1;
    end else begin : g_high
      assign lane[i] = bus_wide;
    end
  end
endmodule

// File: rtl/irqc_status_reg.sv
`timescale 1ns/1ps
module irqc_status_reg #(
  parameter int NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] set_vec,
  input  logic               clr_wr,
  input  logic [NUM_SRC-1:0] lane,
  input  logic [NUM_SRC-1:0] wval,
  output logic [NUM_SRC-1:0] status_q
);
  logic [NUM_SRC-1:0] status_d;
  logic               status_en;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
    assign status_d[i] = set_vec[i] | (status_q[i] & ~(clr_wr & lane[i] & ~wval[i]));
  end

  assign status_en = clr_wr | (|set_vec);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         status_q <= '0;
    else if (status_en) status_q <= status_d;
  end
endmodule

// File: rtl/irqc_mask_reg.sv
`timescale 1ns/1ps
module irqc_mask_reg #(
  parameter int NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mask_wr,
  input  logic [NUM_SRC-1:0] lane,
  input  logic [NUM_SRC-1:0] wval,
  output logic [NUM_SRC-1:0] mask_q
);
  logic [NUM_SRC-1:0] mask_d;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
    assign mask_d[i] = lane[i] ? wval[i] : mask_q[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_wr) mask_q <= mask_d;
  end
endmodule

// File: rtl/irqc_irq_gen.sv
`timescale 1ns/1ps
module irqc_irq_gen #(
  parameter int NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] status,
  input  logic [NUM_SRC-1:0] mask,
  output logic               irq_q
);
  logic any_pend;

  assign any_pend = |(status & mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= any_pend;
  end
endmodule

// File: rtl/irqc_top.sv
`timescale 1ns/1ps
module irqc_top
  import irqc_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int ADDR_W  = 4,
  parameter int DMA_BIT = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_req,
  input  logic               dma_req,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic               bus_wide,
  input  logic [BUS_W-1:0]   bus_wdata,
  output logic [BUS_W-1:0]   bus_rdata,
  output logic               cpu_irq
);
  logic               rst_sync_n;
  logic               stat_wr;
  logic               mask_wr;
  reg_sel_e           rd_sel;
  logic [NUM_SRC-1:0] lane;
  logic [NUM_SRC-1:0] set_vec;
  logic [NUM_SRC-1:0] wval;
  logic [NUM_SRC-1:0] status_q;
  logic [NUM_SRC-1:0] mask_q;
  logic [NUM_SRC-1:0] rd_val;

  assign wval = bus_wdata[NUM_SRC-1:0];

  always_comb begin
    set_vec          = src_req;
    set_vec[DMA_BIT] = src_req[DMA_BIT] | dma_req;
  end

  irqc_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  irqc_bus_decode #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_decode (
    .bus_addr (bus_addr),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_wide (bus_wide),
    .stat_wr  (stat_wr),
    .mask_wr  (mask_wr),
    .rd_sel   (rd_sel),
    .lane     (lane)
  );

  irqc_status_reg #(.NUM_SRC(NUM_SRC)) u_status (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .set_vec  (set_vec),
    .clr_wr   (stat_wr),
    .lane     (lane),
    .wval     (wval),
    .status_q (status_q)
  );

  irqc_mask_reg #(.NUM_SRC(NUM_SRC)) u_mask (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .mask_wr (mask_wr),
    .lane    (lane),
    .wval    (wval),
    .mask_q  (mask_q)
  );

  irqc_irq_gen #(.NUM_SRC(NUM_SRC)) u_irq (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .status (status_q),
    .mask   (mask_q),
    .irq_q  (cpu_irq)
  );

  always_comb begin
    unique case (rd_sel)
      SEL_STATUS: rd_val = status_q;
      SEL_MASK:   rd_val = mask_q;
      default:    rd_val = '0;
    endcase
  end

  assign bus_rdata = BUS_W'(rd_val & lane);
endmodule

// File: rtl/irqc_checker.sv
`timescale 1ns/1ps
module irqc_checker
  import irqc_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int ADDR_W  = 4,
  parameter int DMA_BIT = 3
) (
  input logic               clk,
  input logic               rst_sync_n,
  input logic [NUM_SRC-1:0] src_req,
  input logic               dma_req,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic               bus_wr,
  input logic               bus_wide,
  input logic [BUS_W-1:0]   bus_wdata,
  input logic [NUM_SRC-1:0] status_q,
  input logic [NUM_SRC-1:0] mask_q,
  input logic               cpu_irq
);
  logic [NUM_SRC-1:0] req_all;
  logic               wr_status;
  logic               wr_mask;
  logic               wr_stray;

  always_comb begin
    req_all          = src_req;
    req_all[DMA_BIT] = src_req[DMA_BIT] | dma_req;
  end

  assign wr_status = bus_wr && (bus_addr == ADDR_W'(STATUS_OFF));
  assign wr_mask   = bus_wr && (bus_addr == ADDR_W'(MASK_OFF));
  assign wr_stray  = bus_wr && !wr_status && !wr_mask;

  AST_REQ_STICKS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (|req_all) |=> ((status_q & $past(req_all)) == $past(req_all))); // R2

  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_status && (|req_all)) |=> ((status_q & $past(req_all)) == $past(req_all))); // R9

  AST_NO_WRITE_SET: assert property (@(posedge clk) disable iff (!rst_sync_n)
    1'b1 |=> ((status_q & ~$past(status_q) & ~$past(req_all)) == '0)); // R3

  AST_MASK_FULL_LOAD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_mask && bus_wide) |=> (mask_q == $past(bus_wdata[NUM_SRC-1:0]))); // R5

  if (NUM_SRC > HALF_W) begin : g_half
    AST_MASK_HALF_KEEPS_TOP: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (wr_mask && !bus_wide) |=> (mask_q[NUM_SRC-1:HALF_W] == $past(mask_q[NUM_SRC-1:HALF_W]))); // R6
  end

  AST_IRQ_RISE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (|(status_q & mask_q)) |=> cpu_irq); // R7

  AST_IRQ_FALL: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(|(status_q & mask_q)) |=> !cpu_irq); // R7

  AST_DMA_SETS_BIT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    dma_req |=> status_q[DMA_BIT]); // R10

  AST_STRAY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wr_stray |=> (mask_q == $past(mask_q))); // R11
endmodule

bind irqc_top irqc_checker #(
  .NUM_SRC (NUM_SRC),
  .ADDR_W  (ADDR_W),
  .DMA_BIT (DMA_BIT)
) u_irqc_checker (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .src_req    (src_req),
  .dma_req    (dma_req),
  .bus_addr   (bus_addr),
  .bus_wr     (bus_wr),
  .bus_wide   (bus_wide),
  .bus_wdata  (bus_wdata),
  .status_q   (status_q),
  .mask_q     (mask_q),
  .cpu_irq    (cpu_irq)
);

// File: tb/test_irqc_top.sv
`timescale 1ns/1ps
module test_irqc_top;
  localparam int NSRC = 32;
  localparam int AW   = 4;

  logic            clk;
  logic            rst_n;
  logic [NSRC-1:0] src_req;
  logic            dma_req;
  logic [AW-1:0]   bus_addr;
  logic            bus_wr;
  logic            bus_rd;
  logic            bus_wide;
  logic [31:0]     bus_wdata;
  logic [31:0]     bus_rdata;
  logic            cpu_irq;

  irqc_top #(.NUM_SRC(NSRC), .ADDR_W(AW), .DMA_BIT(3)) i_irqc_top (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_req   (src_req),
    .dma_req   (dma_req),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wide  (bus_wide),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .cpu_irq   (cpu_irq)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  typedef struct {
    bit          is_read;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t       sb_q[$];
  int          n_checks = 0;
  int          n_fail   = 0;
  bit          done     = 1'b0;
  logic [31:0] m_status;
  logic [31:0] m_mask;
  logic        m_irq;

  // monitor: pops expectations and compares against the ports
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (sb_q.size() > 0) begin
        item_t       it;
        logic [31:0] got;
        it  = sb_q.pop_front();
        got = it.is_read ? bus_rdata : {31'b0, cpu_irq};
        n_checks++;
        if (got !== it.exp) begin
          n_fail++;
          $display("FAIL %s %s got %h expected %h", it.tag,
                   it.is_read ? "rdata" : "cpu_irq", got, it.exp);
        end
      end
    end
  end

  // driver: applies one cycle of stimulus, queues expectations, steps the model
  task automatic drive(input logic [31:0] req, input logic dma, input logic wr,
                       input logic rd, input logic wide, input logic [3:0] addr,
                       input logic [31:0] wdata, input string tag);
    logic [31:0] lane_m;
    logic [31:0] setv;
    logic [31:0] sel;
    logic        nxt_irq;
    src_req   = req;
    dma_req   = dma;
    bus_wr    = wr;
    bus_rd    = rd;
    bus_wide  = wide;
    bus_addr  = addr;
    bus_wdata = wdata;
    lane_m    = wide ? 32'hFFFF_FFFF : 32'h0000_FFFF;
    sb_q.push_back('{is_read: 1'b0, exp: {31'b0, m_irq}, tag: tag});
    if (rd) begin
      sel = (addr == 4'h0) ? m_status : (addr == 4'h4) ? m_mask : 32'h0;
      sb_q.push_back('{is_read: 1'b1, exp: sel & lane_m, tag: tag});
    end
    nxt_irq = |(m_status & m_mask);
    setv    = req | (dma ? 32'h8 : 32'h0);
    if (wr && addr == 4'h0) m_status = (m_status & ~(lane_m & ~wdata)) | setv;
    else                    m_status = m_status | setv;
    if (wr && addr == 4'h4) m_mask = (m_mask & ~lane_m) | (wdata & lane_m);
    m_irq = nxt_irq;
    @(negedge clk);
  endtask

  task automatic idle(input string tag);
    drive('0, 1'b0, 1'b0, 1'b0, 1'b1, 4'h0, '0, tag);
  endtask
  task automatic wr_reg(input logic [3:0] a, input logic wide, input logic [31:0] d, input string tag);
    drive('0, 1'b0, 1'b1, 1'b0, wide, a, d, tag);
  endtask
  task automatic rd_reg(input logic [3:0] a, input logic wide, input string tag);
    drive('0, 1'b0, 1'b0, 1'b1, wide, a, '0, tag);
  endtask

  initial begin
    #500000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; src_req = '0; dma_req = 1'b0; bus_addr = '0;
    bus_wr = 1'b0; bus_rd = 1'b0; bus_wide = 1'b1; bus_wdata = '0;
    m_status = '0; m_mask = '0; m_irq = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    rd_reg(4'h0, 1'b1, "R1");
    rd_reg(4'h4, 1'b1, "R1");
    idle("R1");

    // R2: request pulses set sticky bits, mask still zero
    drive(32'h0010_0020, 1'b0, 1'b0, 1'b0, 1'b1, 4'h0, '0, "R2");
    idle("R2");
    idle("R2");
    rd_reg(4'h0, 1'b1, "R2");

    // R5 and R8: full mask write unmasks pending bits, line rises without a new request
    wr_reg(4'h4, 1'b1, 32'h0010_0020, "R8");
    idle("R8");
    idle("R8");
    rd_reg(4'h4, 1'b1, "R5");

    // R6: 16-bit mask write touches only the low half
    wr_reg(4'h4, 1'b0, 32'hFFFF_0000, "R6");
    idle("R6");
    rd_reg(4'h4, 1'b1, "R6");

    // R4: 16-bit status write clears only in the low half
    wr_reg(4'h0, 1'b0, 32'h0000_0000, "R4");
    idle("R4");
    rd_reg(4'h0, 1'b1, "R4");

    // R3: 32-bit AND write acknowledges bit 20; R7: line falls a cycle later
    wr_reg(4'h0, 1'b1, 32'hFFEF_FFFF, "R3");
    idle("R7");
    idle("R7");
    rd_reg(4'h0, 1'b1, "R3");

    // R9: request and clearing write on the same bit
    drive(32'h0000_0080, 1'b0, 1'b1, 1'b0, 1'b1, 4'h0, 32'h0, "R9");
    idle("R9");
    rd_reg(4'h0, 1'b1, "R9");

    // R10: DMA request lands on bit 3
    drive('0, 1'b1, 1'b0, 1'b0, 1'b1, 4'h0, '0, "R10");
    wr_reg(4'h4, 1'b1, 32'h0000_0008, "R10");
    idle("R10");
    rd_reg(4'h0, 1'b1, "R10");
    idle("R10");

    // R11: stray offsets, zero-extended half reads
    drive(32'h8000_0000, 1'b0, 1'b0, 1'b0, 1'b1, 4'h0, '0, "R11");
    wr_reg(4'h8, 1'b1, 32'h0, "R11");
    wr_reg(4'hC, 1'b1, 32'hFFFF_FFFF, "R11");
    rd_reg(4'h8, 1'b1, "R11");
    rd_reg(4'h0, 1'b0, "R11");
    rd_reg(4'h0, 1'b1, "R11");
    rd_reg(4'h4, 1'b1, "R11");

    // R7: mask cleared, line drops
    wr_reg(4'h4, 1'b1, 32'h0, "R7");
    idle("R7");
    idle("R7");

    // mixed traffic against the model
    for (int k = 0; k < 400; k++) begin
      logic [31:0] rq;
      logic [3:0]  a;
      int          pick;
      rq   = $urandom & $urandom & $urandom;
      pick = $urandom_range(0, 3);
      a    = (pick == 0) ? 4'h0 : (pick == 1) ? 4'h4 : (pick == 2) ? 4'h8 : 4'h0;
      drive(rq, 1'($urandom_range(0, 7) == 0), 1'($urandom_range(0, 3) == 0),
            1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), a, $urandom, "R7");
    end
    rd_reg(4'h0, 1'b1, "R3");
    rd_reg(4'h4, 1'b1, "R5");
    idle("R7");
    idle("R7");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule